// File: doc/BRIEF.md
# Pipelined AHB-Lite Memory Subordinate

This block is a small word-organised memory that sits behind a pipelined AHB-Lite port. In each cycle where it is selected and the bus-wide ready input is high, it takes the address-phase controls: transfer type, direction, size and byte address. It then serves the matching data phase in the next cycle. Reads return a full 32-bit word. Writes update only the byte lanes that the transfer size and the low address bits select.

Every legal transfer finishes with zero wait states. An access that is misaligned for its size, or wider than the data bus, is rejected with the standard two-cycle ERROR response and changes no memory. A read placed directly behind a write to the same word returns the data that write just delivered, so a manager can issue back-to-back transfers without stalling.

Top module: `ahbl_mem_sub`

## Requirements
- R1: Out of reset, readyout_o is 1 and resp_o is 0, and every memory word reads as zero.
- R2: Address-phase inputs are taken only in a cycle where sel_i and ready_i are both 1. A write presented with sel_i at 0, or with ready_i at 0, changes no memory.
- R3: A transfer type of 00 (idle) or 01 (busy) causes no memory access and gets a zero-wait OKAY: readyout_o is 1 and resp_o is 0 in the next cycle.
- R4: A legal write of type 10 (non-sequential) or 11 (sequential) stores wdata_i as sampled in its data phase. It updates only the lanes that size_i and addr_i[1:0] select: size 0 is one byte at lane addr[1:0], size 1 is a halfword at lanes {1,0} or {3,2} chosen by addr[1], and size 2 is all four lanes. Lane n is bits 8n+7..8n.
- R5: A legal read returns the whole addressed word on rdata_o in its data phase, the cycle after the address phase, with readyout_o 1 and resp_o 0.
- R6: An access whose byte address is not a multiple of 2^size_i gives the ERROR response and writes nothing.
- R7: An access with size_i greater than 2, meaning wider than 32 bits, gives the ERROR response and writes nothing.
- R8: The ERROR response has two cycles. In the first, resp_o is 1 and readyout_o is 0. In the second, resp_o is 1 and readyout_o is 1. A new address phase offered in that second cycle is accepted.
- R9: A read whose address phase falls in the data phase of a write to the same word returns the word as updated by that write, merged by byte lane.
- R10: Back-to-back legal transfers complete with no wait state. readyout_o is 0 only in the first cycle of an ERROR response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Subordinate select from the address decoder |
| addr_i | input | AW (8) | Byte address |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| write_i | input | 1 | 1 for a write, 0 for a read |
| size_i | input | 3 | Transfer size as log2 of the byte count |
| wdata_i | input | DW (32) | Write data, valid in the write data phase |
| ready_i | input | 1 | Bus-wide ready; the previous transfer has finished |
| readyout_o | output | 1 | This subordinate's data phase is complete |
| resp_o | output | 1 | 1 signals ERROR |
| rdata_o | output | DW (32) | Read data, valid in an OKAY read data phase |

## Verification
One cycle can hold both the data phase of a write and the address phase of a read. The memory commit and the read capture then occur together, and the forwarding path must merge the write's byte lanes into the read word. The bench provokes this with a full-word write followed at once by a same-word read, and then with a single-byte write followed at once by a read. It judges the returned word against a lane-by-lane merge computed from the earlier contents. A second overlap is the second ERROR cycle taking a fresh address phase. The bench queues a legal read while the error is still showing and checks both the error handshake and the data returned after it.

// File: rtl/ahbl_mem_sub.sv
module ahbl_mem_sub #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    trans_i,
  input  logic          write_i,
  input  logic [2:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  output logic          readyout_o,
  output logic          resp_o,
  output logic [DW-1:0] rdata_o
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx_a, dp_idx;
  logic [NB-1:0] be_a, dp_be;
  logic [DW-1:0] rd_word, rdata_q;
  logic          is_xfer, take, misal, too_big, bad;
  logic          dp_wr, err1, err2;

  assign is_xfer = (trans_i == 2'b10) || (trans_i == 2'b11);
  assign take    = sel_i & ready_i & is_xfer;
  assign idx_a   = addr_i[LW +: IW];
  assign too_big = int'(size_i) > LW;
  assign bad     = too_big | misal;

  always_comb begin
    int lo;
    lo    = int'(addr_i[LW-1:0]);
    misal = (lo & ((1 << size_i) - 1)) != 0;
    for (int k = 0; k < NB; k++)
      be_a[k] = (k >> size_i) == (lo >> size_i);
  end

  always_comb begin
    for (int k = 0; k < NB; k++)
      rd_word[k*8 +: 8] = (dp_wr && dp_idx == idx_a && dp_be[k]) ?
                          wdata_i[k*8 +: 8] : mem[idx_a][k*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_wr   <= 1'b0;
      dp_idx  <= '0;
      dp_be   <= '0;
      err1    <= 1'b0;
      err2    <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      err1  <= take & bad;
      err2  <= err1;
      dp_wr <= take & ~bad & write_i;
      if (take) begin
        dp_idx <= idx_a;
        dp_be  <= be_a;
      end
      if (take && !bad && !write_i) rdata_q <= rd_word;
      if (dp_wr)
        for (int k = 0; k < NB; k++)
          if (dp_be[k]) mem[dp_idx][k*8 +: 8] <= wdata_i[k*8 +: 8];
    end
  end

  assign readyout_o = ~err1;
  assign resp_o     = err1 | err2;
  assign rdata_o    = rdata_q;

  assert_err_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |=> (resp_o && readyout_o));

  assert_misaligned_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && misal) |=> (resp_o && !readyout_o));

  assert_oversize_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ready_i && is_xfer && size_i > 3'(LW)) |=> (resp_o && !readyout_o));

  assert_no_write_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |-> !dp_wr);

  assert_idle_okay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ready_i && (trans_i == 2'b00 || trans_i == 2'b01)) |=> (readyout_o && !resp_o));

  assert_wait_only_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !readyout_o |-> resp_o);
endmodule

// File: tb/tb_ahbl_mem_sub.sv
module tb_ahbl_mem_sub;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, ovr = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  trans = IDLE;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        readyout, resp, ready;
  logic [31:0] rdata;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  assign ready = ovr ? 1'b0 : readyout;
  always #(CLK_PERIOD/2) clk = ~clk;

  ahbl_mem_sub dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .trans_i(trans),
    .write_i(wr), .size_i(size), .wdata_i(wdata), .ready_i(ready),
    .readyout_o(readyout), .resp_o(resp), .rdata_o(rdata));

  function automatic logic [83:0] mk(int r, logic [1:0] t, logic w, logic [2:0] s,
      logic [7:0] a, logic [31:0] d, logic e, logic c, logic [31:0] x);
    return {4'(r), t, w, s, a, d, e, c, x};
  endfunction

  localparam int NV = 16;
  localparam logic [83:0] VEC [NV] = '{
    mk(4, NSEQ, 1, 2, 8'h10, 32'hA1B2C3D4, 0, 0, 0),  // R4 word write
    mk(5, NSEQ, 0, 2, 8'h10, 0, 0, 1, 32'hA1B2C3D4),  // R5 read back
    mk(4, NSEQ, 1, 0, 8'h11, 32'h11223344, 0, 0, 0),  // R4 byte lane 1
    mk(4, NSEQ, 0, 2, 8'h10, 0, 0, 1, 32'hA1B233D4),
    mk(4, NSEQ, 1, 1, 8'h12, 32'hBEEF0000, 0, 0, 0),  // R4 upper half
    mk(4, NSEQ, 0, 2, 8'h10, 0, 0, 1, 32'hBEEF33D4),
    mk(6, NSEQ, 1, 2, 8'h16, 32'hFFFFFFFF, 1, 0, 0),  // R6 misaligned word
    mk(6, NSEQ, 1, 1, 8'h13, 32'hFFFFFFFF, 1, 0, 0),  // R6 misaligned half
    mk(7, NSEQ, 1, 3, 8'h10, 32'hFFFFFFFF, 1, 0, 0),  // R7 oversize
    mk(7, NSEQ, 0, 4, 8'h10, 0, 1, 0, 0),             // R7 oversize read
    mk(6, NSEQ, 0, 2, 8'h10, 0, 0, 1, 32'hBEEF33D4),  // R6 R7 nothing written
    mk(3, IDLE, 1, 2, 8'h10, 32'h0, 0, 0, 0),         // R3 idle
    mk(3, BUSY, 1, 2, 8'h10, 32'h0, 0, 0, 0),         // R3 busy
    mk(3, SEQ,  0, 2, 8'h10, 0, 0, 1, 32'hBEEF33D4),
    mk(4, SEQ,  1, 0, 8'h17, 32'h77000000, 0, 0, 0),  // R4 byte lane 3
    mk(4, NSEQ, 0, 2, 8'h14, 0, 0, 1, 32'h77000000)
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [83:0] v, int i);
    string tag;
    tag = $sformatf("R%0d vec%0d", int'(v[83:80]), i);
    @(negedge clk);
    sel = 1; trans = v[79:78]; wr = v[77]; size = v[76:74]; addr = v[73:66];
    @(negedge clk);
    sel = 0; trans = IDLE; wdata = v[65:34];
    if (v[33]) begin
      check({tag, " err1"}, {30'b0, resp, readyout}, 32'd2);
      @(negedge clk);
      check({tag, " err2 R8"}, {30'b0, resp, readyout}, 32'd3);
    end else begin
      check({tag, " okay"}, {30'b0, resp, readyout}, 32'd1);
      if (v[32]) check({tag, " rdata"}, rdata, v[31:0]);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    sel = 1; trans = NSEQ; wr = 0; size = 2; addr = a;
    @(negedge clk);
    sel = 0; trans = IDLE;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset handshake", {30'b0, resp, readyout}, 32'd1);
    rst_n = 1;
    rd(8'h10, 32'h0, "R1 memory cleared");

    for (int i = 0; i < NV; i++) run(VEC[i], i);

    // R2: write with select low, then with bus ready held low
    @(negedge clk);
    sel = 0; trans = NSEQ; wr = 1; size = 2; addr = 8'h30;
    @(negedge clk);
    trans = IDLE; wdata = 32'hFFFFFFFF;
    @(negedge clk);
    sel = 1; trans = NSEQ; wr = 1; size = 2; addr = 8'h30; ovr = 1;
    @(negedge clk);
    sel = 0; trans = IDLE; ovr = 0; wdata = 32'hFFFFFFFF;
    rd(8'h30, 32'h0, "R2 unselected writes ignored");

    // R9 R10: write then same-word read back to back
    @(negedge clk);
    sel = 1; trans = NSEQ; wr = 1; size = 2; addr = 8'h20;
    @(negedge clk);
    trans = SEQ; wr = 0; addr = 8'h20; wdata = 32'hCAFEF00D;
    check("R10 no wait back-to-back", {30'b0, resp, readyout}, 32'd1);
    @(negedge clk);
    sel = 0; trans = IDLE;
    check("R9 forwarded word", rdata, 32'hCAFEF00D);
    @(negedge clk);
    sel = 1; trans = NSEQ; wr = 1; size = 0; addr = 8'h21;
    @(negedge clk);
    wr = 0; size = 2; addr = 8'h20; wdata = 32'h0000AB00;
    @(negedge clk);
    sel = 0; trans = IDLE;
    check("R9 forwarded byte merge", rdata, 32'hCAFEAB0D);

    // R8: read queued behind an error, taken in second error cycle
    @(negedge clk);
    sel = 1; trans = NSEQ; wr = 0; size = 2; addr = 8'h22;
    @(negedge clk);
    addr = 8'h20;
    check("R8 first cycle", {30'b0, resp, readyout}, 32'd2);
    @(negedge clk);
    check("R8 second cycle", {30'b0, resp, readyout}, 32'd3);
    @(negedge clk);
    sel = 0; trans = IDLE;
    check("R8 read after error", {30'b0, resp, readyout}, 32'd1);
    check("R8 read data after error", rdata, 32'hCAFEAB0D);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule